// File: doc/BRIEF.md
# Per-Channel Interrupt Status Controller

This block gathers single-cycle event pulses from up to four command channels and turns them into one level interrupt. Every channel owns an 8-bit lane of a 32-bit cause word, and five bits of that lane are used. The five causes are a finished command, a receive overrun, a transmit underrun, a poll timeout and an invalid control word. Each bit latches when its pulse arrives and stays set until software clears it. The upper byte can also hold spare global bits. These bits latch and clear like the cause bits, but no interrupt logic uses them.

Software reaches three registers through a plain 32-bit read/write port: the sticky status, an enable mask, and a read-only view of status AND mask. The interrupt output is registered. It is high one cycle after the masked view becomes non-zero. A typical handler reads the masked view, clears the status with a single write of the clear-all pattern, and writes zero to the mask to silence the line while it works.

Top module: `irq_status_ctrl`

## Requirements
- R1: A one-cycle pulse on a cause input of channel i sets status bit 8*i+k on the next clock edge, where k is 0 for command done, 1 for receive overrun, 2 for transmit underrun, 3 for poll timeout and 4 for invalid control.
- R2: A set status bit stays set across idle cycles and across writes of 0 to that bit.
- R3: Writing 1 to a status bit clears it. When an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R4: Register addresses are 0x08 for status, 0x0C for masked status and 0x10 for mask. Any other address reads 0, and writes to it change nothing.
- R5: The masked status at 0x0C reads status AND mask. Writes to 0x0C have no effect.
- R6: The irq output is registered. After any clock edge it equals the OR of the masked status that was held before that edge.
- R7: With the mask at zero, irq stays low and the raw status still reads back its set bits.
- R8: Writing 0xFF001F1F to status clears every bit of channels 0 and 1 and every bit in 31:24. Bits of channel 2 are left alone.
- R9: Bits outside the implemented set read as 0 in status, mask and masked status, and writes to them are ignored. The implemented set is the five low bits of each channel lane plus bits 31:24. A spare pulse on spare_ev[j] sets bit 24+j only where that bit is not inside a channel lane.
- R10: After reset, status, mask and masked status read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done | input | NUM_CH | Command-done pulse per channel |
| ev_rx_ovr | input | NUM_CH | Receive-overrun pulse per channel |
| ev_tx_und | input | NUM_CH | Transmit-underrun pulse per channel |
| ev_poll_to | input | NUM_CH | Poll-timeout pulse per channel |
| ev_ctl_bad | input | NUM_CH | Invalid-control pulse per channel |
| spare_ev | input | 8 | Pulses for the spare upper-byte bits |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with NUM_CH = 4, the largest channel count. With four channels, lane 3 fills bits 28:24 and only bits 31:29 remain as spare latches, so the overlap between channel lanes and the spare byte is exercised. This count also gives a lane 2 that the clear-all pattern leaves untouched, which shows that the pattern clears exactly its own bits and nothing more. Random events and register writes then drive the design against a bench model that covers every lane and the spare bits together.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev_done,
  input  logic [NUM_CH-1:0] ev_rx_ovr,
  input  logic [NUM_CH-1:0] ev_tx_und,
  input  logic [NUM_CH-1:0] ev_poll_to,
  input  logic [NUM_CH-1:0] ev_ctl_bad,
  input  logic [7:0]        spare_ev,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_MSKD = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h10);

  function automatic logic [31:0] lane_bits();
    logic [31:0] m = '0;
    for (int c = 0; c < NUM_CH; c++) m[8*c +: 5] = 5'h1F;
    return m;
  endfunction

  localparam logic [31:0] LANES = lane_bits();
  localparam logic [31:0] IMPL  = LANES | 32'hFF00_0000;

  logic [31:0] status_q, mask_q, set_vec, clr_vec;
  logic        wr_stat, wr_mask;

  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_mask = reg_wr && (reg_addr == A_MASK);
  assign clr_vec = wr_stat ? (reg_wdata & IMPL) : '0;

  always_comb begin
    set_vec = {spare_ev, 24'h0} & ~LANES;
    for (int c = 0; c < NUM_CH; c++) begin
      set_vec[8*c + 0] = ev_done[c];
      set_vec[8*c + 1] = ev_rx_ovr[c];
      set_vec[8*c + 2] = ev_tx_und[c];
      set_vec[8*c + 3] = ev_poll_to[c];
      set_vec[8*c + 4] = ev_ctl_bad[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= ((status_q & ~clr_vec) | set_vec) & IMPL;
      if (wr_mask) mask_q <= reg_wdata & IMPL;
      irq <= |(status_q & mask_q);
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_STAT:  reg_rdata = status_q;
      A_MSKD:  reg_rdata = status_q & mask_q;
      A_MASK:  reg_rdata = mask_q;
      default: reg_rdata = '0;
    endcase
  end

  assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((status_q & $past(reg_wdata & IMPL & ~set_vec)) == 0));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));

  assert_quiet_when_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 0) |=> !irq);

endmodule

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
  localparam int NCH = 4;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] d = 0, rx = 0, tx = 0, po = 0, cb = 0;
  logic [7:0]  sp = 0;
  logic [7:0]  addr = 0;
  logic        wr = 0;
  logic [31:0] wd = 0;
  logic [31:0] rd;
  logic        irq;

  int total = 0, bad = 0;
  logic [31:0] es = 0, em = 0;
  logic        ei = 0;

  always #2.5 clk = ~clk;

  irq_status_ctrl #(.NUM_CH(NCH), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_done(d), .ev_rx_ovr(rx), .ev_tx_und(tx),
    .ev_poll_to(po), .ev_ctl_bad(cb), .spare_ev(sp), .reg_addr(addr),
    .reg_wr(wr), .reg_wdata(wd), .reg_rdata(rd), .irq(irq));

  function automatic logic [31:0] lanes_f();
    logic [31:0] m = 0;
    for (int c = 0; c < NCH; c++) m[8*c +: 5] = 5'h1F;
    return m;
  endfunction

  function automatic logic [31:0] impl_f();
    return lanes_f() | 32'hFF00_0000;
  endfunction

  function automatic logic [31:0] set_f();
    logic [31:0] s = {sp, 24'h0} & ~lanes_f();
    for (int c = 0; c < NCH; c++)
      s[8*c +: 5] = {cb[c], po[c], tx[c], rx[c], d[c]};
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #0.5;
    chk(req, rd, exp);
  endtask

  task automatic cyc();
    logic [31:0] clr;
    logic [31:0] nxt_s, nxt_m;
    clr   = (wr && addr == 8'h08) ? wd : 0;
    nxt_s = ((es & ~clr) | set_f()) & impl_f();
    nxt_m = (wr && addr == 8'h10) ? (wd & impl_f()) : em;
    @(posedge clk);
    ei = |(es & em);
    es = nxt_s;
    em = nxt_m;
    @(negedge clk);
    d = 0; rx = 0; tx = 0; po = 0; cb = 0; sp = 0; wr = 0; wd = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] v);
    addr = a; wr = 1; wd = v;
    cyc();
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk("R10 status", 8'h08, 0);
    rd_chk("R10 mask", 8'h10, 0);
    rd_chk("R10 masked", 8'h0C, 0);
    chk("R10 irq", {31'b0, irq}, 0);

    // R1: each cause of each channel lands at 8*i+k
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 5; k++) begin
        case (k)
          0: d[c] = 1;
          1: rx[c] = 1;
          2: tx[c] = 1;
          3: po[c] = 1;
          default: cb[c] = 1;
        endcase
        cyc();
        rd_chk("R1 bit position", 8'h08, es);
        wr_reg(8'h08, 32'hFFFF_FFFF);
      end
    end
    d[1] = 1; cyc();
    rd_chk("R1 ch1 done", 8'h08, 32'h0000_0100);

    // R2: sticky across idle and writes of zero
    repeat (3) cyc();
    wr_reg(8'h08, 0);
    rd_chk("R2 sticky", 8'h08, 32'h0000_0100);

    // R9: spare bits and unimplemented mask bits
    sp = 8'hFF; cyc();
    rd_chk("R9 spare only 31:29", 8'h08, 32'hE000_0100);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    chk("R6 irq not yet", {31'b0, irq}, 0);
    rd_chk("R9 mask impl", 8'h10, 32'hFF1F_1F1F);
    rd_chk("R5 masked", 8'h0C, 32'hE000_0100);
    cyc();
    chk("R6 irq one cycle later", {31'b0, irq}, 1);

    // R5 / R4 ignored writes
    wr_reg(8'h0C, 0);
    rd_chk("R5 masked unchanged", 8'h0C, 32'hE000_0100);
    rd_chk("R5 mask unchanged", 8'h10, 32'hFF1F_1F1F);
    wr_reg(8'h14, 32'hFFFF_FFFF);
    rd_chk("R4 other addr reads 0", 8'h14, 0);
    rd_chk("R4 status untouched", 8'h08, 32'hE000_0100);

    // R8 clear-all
    d = 4'b1111; po = 4'b0100; cyc();
    wr_reg(8'h08, 32'hFF00_1F1F);
    rd_chk("R8 clear-all keeps lane 2", 8'h08, 32'h0009_0000);

    // R3 set wins over clear
    addr = 8'h08; wr = 1; wd = 32'h0000_0001; d[0] = 1;
    cyc();
    rd_chk("R3 set wins", 8'h08, 32'h0009_0001);
    wr_reg(8'h08, 32'h0001_0000);
    rd_chk("R3 w1c", 8'h08, 32'h0008_0001);

    // R7 mask zero silences irq
    wr_reg(8'h10, 0);
    cyc();
    chk("R7 irq low", {31'b0, irq}, 0);
    rd_chk("R7 raw readable", 8'h08, 32'h0008_0001);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      d  = NCH'($urandom & $urandom & $urandom);
      rx = NCH'($urandom & $urandom & $urandom);
      tx = NCH'($urandom & $urandom & $urandom);
      po = NCH'($urandom & $urandom & $urandom);
      cb = NCH'($urandom & $urandom & $urandom);
      sp = 8'($urandom & $urandom & $urandom);
      if ($urandom % 4 == 0) begin
        wr = 1;
        case ($urandom % 5)
          0: addr = 8'h08;
          1: addr = 8'h0C;
          2: addr = 8'h10;
          3: addr = 8'h14;
          default: addr = 8'h08;
        endcase
        wd = ($urandom % 6 == 0) ? 32'hFF00_1F1F : $urandom;
      end else begin
        addr = 8'h00;
      end
      cyc();
      chk("R6 irq random", {31'b0, irq}, {31'b0, ei});
      case (n % 3)
        0: rd_chk("R2 R3 status random", 8'h08, es);
        1: rd_chk("R5 masked random", 8'h0C, es & em);
        default: rd_chk("R9 mask random", 8'h10, em);
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule